// File: doc/BRIEF.md
# Frame-Synchronous Byte Scrambler

This block scrambles an outgoing byte-wide SONET/SDH STS-N stream before it is serialized. Each data bit is XORed with one bit of a 127-bit pseudo-random sequence from the generator polynomial 1 + x^6 + x^7. The block produces eight sequence bits per clock. The first sequence bit goes to the most significant data bit.

A frame-start strobe marks the first framing byte of a frame, and the block counts byte positions from that strobe. The framing and trace/growth bytes at the head of row 1 pass through unscrambled. There are three groups of them, STS_N bytes each. While those bytes pass, the generator holds its seed of all ones. Scrambling then starts at the first byte after that region, so the sequence is restarted once per frame. If no new strobe arrives, the position counter wraps at the frame length by itself. A strobe in mid-frame realigns the count at once. An enable input turns scrambling off and passes data straight through. The generator keeps running while scrambling is off, so when it is turned back on the sequence is still aligned to the frame.

Top module: `sonet_frame_scrambler`

## Requirements
- R1: While rst_ni is low, data_o is 0x00. The first byte accepted after reset is treated as byte position 0 of a frame.
- R2: data_o carries the result for the byte presented on data_i exactly one clock earlier.
- R3: Byte positions 0 to 3*STS_N-1 of a frame appear on data_o unchanged. Position 0 is the byte that arrives with frame_start_i high.
- R4: The byte at position 3*STS_N is XORed with the first eight sequence bits from the all-ones seed, 0xFE, with the first sequence bit on bit 7.
- R5: Each later byte of the frame is XORed with the next eight bits of the 1 + x^6 + x^7 sequence, MSB first. The generator advances only on bytes at position 3*STS_N or later.
- R6: On an all-zero input, the scrambled bit stream repeats with a period of 127 bits.
- R7: Without a new frame_start_i, the position wraps from 810*STS_N-1 to 0. The next frame is then skipped and reseeded as in R3 and R4.
- R8: With scr_en_i low, data_o equals the input byte. The generator still advances, so bytes scrambled after scr_en_i goes high again use the same mask they would have used had scrambling never been turned off.
- R9: A frame_start_i in mid-frame sets that byte to position 0 at once. The skip region and the reseed follow from that byte.
- R10: XORing data_o with the same frame-aligned sequence returns the original input bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Byte clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| data_i | input | 8 | Outgoing byte before scrambling |
| frame_start_i | input | 1 | High on the first framing byte of a frame |
| scr_en_i | input | 1 | 1 = scramble, 0 = pass through |
| data_o | output | 8 | Scrambled byte, one cycle later |

## Verification
On every cycle the assertions check four things: skipped positions and disabled cycles reproduce the input, the generator holds the all-ones seed at the first scrambled position, the generator state is never zero, and the position never leaves the frame. The bench compares every output byte with a bit-serial model of the sequence, and only that comparison can show that the mask values are correct. The scenarios also cover the handling of a mid-frame strobe, alignment after the enable is toggled, the automatic frame wrap, and the 127-bit period.

// File: rtl/sfs_pkg.sv
package sfs_pkg;
  localparam int unsigned LFSR_W = 7;
  typedef logic [LFSR_W-1:0] lfsr_t;
  localparam lfsr_t LFSR_SEED = '1;

  // one serial step of 1 + x^6 + x^7, output taken from the top stage
  function automatic lfsr_t lfsr_step(input lfsr_t s);
    return {s[LFSR_W-2:0], s[LFSR_W-1] ^ s[LFSR_W-2]};
  endfunction
endpackage

// File: rtl/sfs_pos_tracker.sv
module sfs_pos_tracker #(
  parameter int unsigned FRAME_BYTES = 2430,
  parameter int unsigned SKIP_BYTES  = 9,
  localparam int unsigned POS_W = $clog2(FRAME_BYTES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             frame_start_i,
  output logic [POS_W-1:0] pos_o,
  output logic             skip_o
);
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(FRAME_BYTES - 1);
  localparam logic [POS_W-1:0] SKIP_END = POS_W'(SKIP_BYTES);

  logic [POS_W-1:0] cnt_q;

  assign pos_o  = frame_start_i ? '0 : cnt_q;
  assign skip_o = pos_o < SKIP_END;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (pos_o == LAST_POS) cnt_q <= '0;
    else                        cnt_q <= pos_o + 1'b1;
  end
endmodule

// File: rtl/sfs_keystream.sv
module sfs_keystream
  import sfs_pkg::*;
#(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reseed_i,
  output logic [BYTE_W-1:0] mask_o,
  output lfsr_t             state_o
);
  lfsr_t state_q;
  lfsr_t chain [BYTE_W+1];

  assign chain[0] = state_q;

  for (genvar b = 0; b < BYTE_W; b++) begin : g_bit
    assign mask_o[BYTE_W-1-b] = chain[b][LFSR_W-1];
    assign chain[b+1]         = lfsr_step(chain[b]);
  end

  // hold seed across skipped bytes, advance otherwise
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       state_q <= LFSR_SEED;
    else if (reseed_i) state_q <= LFSR_SEED;
    else               state_q <= chain[BYTE_W];
  end

  assign state_o = state_q;
endmodule

// File: rtl/sonet_frame_scrambler.sv
module sonet_frame_scrambler
  import sfs_pkg::*;
#(
  parameter int unsigned STS_N = 3,
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned FRAME_BYTES = 810 * STS_N,
  localparam int unsigned SKIP_BYTES  = 3 * STS_N,
  localparam int unsigned POS_W       = $clog2(FRAME_BYTES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BYTE_W-1:0] data_i,
  input  logic              frame_start_i,
  input  logic              scr_en_i,
  output logic [BYTE_W-1:0] data_o
);
  logic [POS_W-1:0]  byte_pos;
  logic              in_skip;
  logic [BYTE_W-1:0] mask;
  lfsr_t             lfsr_state;
  logic [BYTE_W-1:0] data_q;

  sfs_pos_tracker #(
    .FRAME_BYTES(FRAME_BYTES),
    .SKIP_BYTES (SKIP_BYTES)
  ) u_pos (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .frame_start_i(frame_start_i),
    .pos_o        (byte_pos),
    .skip_o       (in_skip)
  );

  sfs_keystream #(.BYTE_W(BYTE_W)) u_ks (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .reseed_i(in_skip),
    .mask_o  (mask),
    .state_o (lfsr_state)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   data_q <= '0;
    else if (scr_en_i && !in_skip) data_q <= data_i ^ mask;
    else                           data_q <= data_i;
  end

  assign data_o = data_q;
endmodule

// File: rtl/sfs_checker.sv
module sfs_checker
  import sfs_pkg::*;
#(
  parameter int unsigned STS_N = 3,
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned FRAME_BYTES = 810 * STS_N,
  localparam int unsigned SKIP_BYTES  = 3 * STS_N,
  localparam int unsigned POS_W       = $clog2(FRAME_BYTES)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [BYTE_W-1:0] data_i,
  input logic              scr_en_i,
  input logic [BYTE_W-1:0] data_o,
  input logic [POS_W-1:0]  pos,
  input logic              skip,
  input lfsr_t             lfsr_q
);
  a_r3_skip_passthru: assert property (@(posedge clk_i) disable iff (!rst_ni)
    skip |=> data_o == $past(data_i));

  a_r8_bypass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !scr_en_i |=> data_o == $past(data_i));

  a_r4_seed_at_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pos == POS_W'(SKIP_BYTES)) |-> lfsr_q == LFSR_SEED);

  a_r5_state_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lfsr_q != '0);

  a_r7_pos_in_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pos < POS_W'(FRAME_BYTES));
endmodule

bind sonet_frame_scrambler sfs_checker #(.STS_N(STS_N), .BYTE_W(BYTE_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .data_i  (data_i),
  .scr_en_i(scr_en_i),
  .data_o  (data_o),
  .pos     (byte_pos),
  .skip    (in_skip),
  .lfsr_q  (lfsr_state)
);

// File: tb/sonet_frame_scrambler_test.sv
module sonet_frame_scrambler_test;
  localparam int CLK_PERIOD = 10;
  localparam int STS_N = 3;
  localparam int FRAME = 810 * STS_N;
  localparam int SKIP = 3 * STS_N;

  logic       clk = 0;
  logic       rst_n = 0;
  logic [7:0] din = 0;
  logic       fs = 0;
  logic       en = 0;
  logic [7:0] dout;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  int         mpos = 0;
  logic [6:0] ms = 7'h7f;
  string      src = "R4";
  bit         first = 1;
  bit         pend = 0, pend_scr = 0;
  logic [7:0] pend_exp, pend_in, pend_mask;
  string      pend_tag;
  int         pend_p;
  bit         cap = 0;
  logic [7:0] capbuf [40];

  sonet_frame_scrambler #(.STS_N(STS_N)) uut (
    .clk_i(clk), .rst_ni(rst_n), .data_i(din),
    .frame_start_i(fs), .scr_en_i(en), .data_o(dout)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  // bit-serial model of 1 + x^6 + x^7, first bit to MSB
  function automatic logic [7:0] model_mask(inout logic [6:0] s);
    logic [7:0] m;
    for (int i = 0; i < 8; i++) begin
      m[7-i] = s[6];
      s = {s[5:0], s[6] ^ s[5]};
    end
    return m;
  endfunction

  task automatic cycle(bit f, bit e, logic [7:0] d);
    int p;
    @(negedge clk);
    if (pend) begin
      check(pend_tag, dout, pend_exp);
      if (pend_scr) check("R10", dout ^ pend_mask, pend_in);
      if (cap && pend_p >= SKIP && pend_p < SKIP + 40) capbuf[pend_p-SKIP] = dout;
    end
    p = f ? 0 : mpos;
    if (f) src = (mpos != 0) ? "R9" : "R4";
    else if (p == 0) src = "R7";
    pend_in = d; pend_p = p; pend_scr = 0; pend_mask = 0;
    if (p < SKIP) begin
      pend_exp = d; ms = 7'h7f;
      pend_tag = first ? "R2" : "R3";
      first = 0;
    end else begin
      pend_mask = model_mask(ms);
      pend_exp = e ? d ^ pend_mask : d;
      pend_scr = e;
      pend_tag = !e ? "R8" : (p == SKIP ? src : "R5");
    end
    mpos = (p == FRAME - 1) ? 0 : p + 1;
    pend = 1;
    fs = f; en = e; din = d;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    end
    $finish;
  end

  initial begin
    bit e;
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    check("R1", dout, 8'h00);
    @(negedge clk);
    rst_n = 1;
    // R3/R4/R5 then auto wrap R7 over two frames
    cycle(1, 1, 8'h00);
    for (int i = 1; i < 2 * FRAME + 20; i++) cycle(0, 1, 8'($urandom));
    // R8 enable toggling with aligned resume
    e = 1;
    for (int i = 0; i < 6000; i++) begin
      if ($urandom_range(0, 49) == 0) e = ~e;
      cycle($urandom_range(0, 1999) == 0, e, 8'($urandom));
    end
    // R9 directed mid-frame strobe
    while (mpos != 1000) cycle(0, 1, 8'($urandom));
    cycle(1, 1, 8'($urandom));
    for (int i = 0; i < 40; i++) cycle(0, 1, 8'($urandom));
    cycle(1, 1, 8'($urandom));
    for (int i = 0; i < 3; i++) cycle(0, 0, 8'($urandom));
    for (int i = 0; i < 30; i++) cycle(0, 1, 8'($urandom));
    // R6 period on all-zero input
    cap = 1;
    cycle(1, 1, 8'h00);
    for (int i = 1; i < SKIP + 42; i++) cycle(0, 1, 8'h00);
    cycle(0, 1, 8'h00);
    cap = 0;
    begin
      int bad = 0;
      for (int k = 0; k < 320 - 127; k++)
        if (capbuf[k/8][7-k%8] !== capbuf[(k+127)/8][7-(k+127)%8]) bad++;
      check("R6", 8'(bad), 8'h00);
    end
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    end
    $finish;
  end
endmodule